// File: doc/BRIEF.md
# BCD Calendar Core with Shadow Byte File

This block keeps the time of day and the calendar date as packed BCD bytes. The fields are seconds, minutes, hours, day of month, month, a two-digit year, a weekday and a week number. A one-cycle 1 Hz enable from an external prescaler advances the count. Seconds carry into minutes, then hours, days, months and years. The day wraps according to the length of the month, with a leap February in every year divisible by four.

Software never reaches the counting registers directly. A ten-byte shadow file sits between the host port and the clock. Location 0 holds a control byte, location 1 holds a report byte, and locations 2 to 9 hold one clock field each. A load command copies the eight shadow field bytes into the clock and clears location 1. The load is refused while the lock bit in location 0 is set. A snapshot command copies the running clock into the eight field bytes. When a snapshot and a tick fall in the same cycle, the snapshot captures the value after the tick, so no torn combination can appear. When a load and a tick fall in the same cycle, the load wins.

The host port is a plain single-cycle register port. A write always completes in the cycle it is presented, and a read is combinational. No back-pressure exists at any edge of the block: every input is accepted in the cycle it is asserted.

Top module: `cal_core`

## Requirements
- R1: After reset, every shadow location reads 00. A snapshot taken before any tick or load returns seconds 00, minutes 00, hours 00, day 01, month 01, year 00, weekday 01 and week 00.
- R2: A write to locations 0 to 9 takes effect on the next clock edge, and rd_data reflects rd_addr combinationally. Addresses 10 to 15 read 00, and writes to them are ignored.
- R3: On a tick, seconds count 00–59 in BCD. Wrapping seconds advances minutes 00–59, and wrapping minutes advances hours 00–23.
- R4: When hours wrap, the day advances. The last day is 31, 30 for months 04/06/09/11, 28 for month 02, or 29 for month 02 when the year, read as a decimal number, is divisible by 4. The day after the last is 01.
- R5: When the day wraps, month 12 goes to 01 and advances the year. Year 99 wraps to 00.
- R6: Every day carry moves the weekday 01..07 on, with 07 going to 01. The week number increments when the weekday goes to 01 and saturates at 52. A month wrap from 12 to 01 resets the week number to 00, and this reset takes precedence over the increment.
- R7: A load command with the lock clear copies shadow locations 2..9 into the clock and clears location 1 at the same edge. The byte order in the shadow is 2 seconds, 3 minutes, 4 hours, 5 day, 6 month, 7 year, 8 weekday, 9 week.
- R8: While bit 7 of location 0 is 1, a load command changes neither the clock nor location 1.
- R9: A snapshot command writes the clock into locations 2..9 at the next edge, using the value the clock takes at that edge. If a tick arrives in the same cycle, the captured value includes that tick. The snapshot also overrides a host write to locations 2..9 in the same cycle.
- R10: A load accepted in the same cycle as a tick sets the clock to exactly the shadow contents, and the tick is lost.
- R11: With neither a tick nor an accepted load, the clock holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle advance enable, one per second |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write location |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | 4 | Host read location |
| rd_data | output | 8 | Byte at rd_addr |
| cmd_load | input | 1 | Copy shadow fields into the clock (lock permitting) |
| cmd_snap | input | 1 | Copy the clock into the shadow fields |

## Verification
The deepest carry paths are hard to reach from the ports: a year-end or leap-February rollover would need millions of ticks from reset. The stimulus therefore uses the load command to place the clock one second before each boundary, applies a single tick, and reads the result back through a snapshot. The same-cycle cases are driven by asserting the command and the tick in one cycle. This covers a snapshot together with a tick and a load together with a tick.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int N_LOC  = 10;
  localparam int T_BASE = 2;
  localparam int N_FLD  = N_LOC - T_BASE;
  localparam logic [BYTE_W-1:0] WEEK_MAX = 8'h52;

  // field 0 (lowest byte) is seconds, matching shadow location T_BASE
  typedef struct packed {
    logic [BYTE_W-1:0] wkno;
    logic [BYTE_W-1:0] wday;
    logic [BYTE_W-1:0] year;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] day;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } cal_time_t;

  localparam cal_time_t TIME_RST = '{wkno: 8'h00, wday: 8'h01, year: 8'h00,
                                     mon: 8'h01, day: 8'h01, hour: 8'h00,
                                     min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  cal_time_t cur,
  output cal_time_t nxt
);
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, wd_wrap;

  always_comb begin
    s_wrap  = (cur.sec == 8'h59);
    m_wrap  = s_wrap && (cur.min == 8'h59);
    h_wrap  = m_wrap && (cur.hour == 8'h23);
    d_wrap  = h_wrap && (cur.day == last_day(cur.mon, cur.year));
    mo_wrap = d_wrap && (cur.mon == 8'h12);
    wd_wrap = h_wrap && (cur.wday == 8'h07);

    nxt.sec  = s_wrap ? 8'h00 : bcd_inc(cur.sec);
    nxt.min  = !s_wrap ? cur.min  : (m_wrap ? 8'h00 : bcd_inc(cur.min));
    nxt.hour = !m_wrap ? cur.hour : (h_wrap ? 8'h00 : bcd_inc(cur.hour));
    nxt.day  = !h_wrap ? cur.day  : (d_wrap ? 8'h01 : bcd_inc(cur.day));
    nxt.wday = !h_wrap ? cur.wday : (wd_wrap ? 8'h01 : bcd_inc(cur.wday));
    nxt.mon  = !d_wrap ? cur.mon  : (mo_wrap ? 8'h01 : bcd_inc(cur.mon));
    nxt.year = !mo_wrap ? cur.year : ((cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year));
    if (mo_wrap)
      nxt.wkno = 8'h00;
    else if (wd_wrap && cur.wkno != WEEK_MAX)
      nxt.wkno = bcd_inc(cur.wkno);
    else
      nxt.wkno = cur.wkno;
  end
endmodule

// File: rtl/cal_shadow.sv
module cal_shadow
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              snap_en,
  input  cal_time_t         snap_val,
  input  logic              clr_stat1,
  output logic              lock,
  output cal_time_t         fields
);
  logic [BYTE_W-1:0] loc_q [N_LOC];

  for (genvar g = 0; g < N_LOC; g++) begin : g_loc
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));
    if (g >= T_BASE) begin : g_fld
      always_ff @(posedge clk) begin
        if (!rst_n)       loc_q[g] <= '0;
        else if (snap_en) loc_q[g] <= snap_val[BYTE_W*(g-T_BASE) +: BYTE_W];
        else if (hit)     loc_q[g] <= wr_data;
      end
      assign fields[BYTE_W*(g-T_BASE) +: BYTE_W] = loc_q[g];
    end else if (g == 1) begin : g_st1
      always_ff @(posedge clk) begin
        if (!rst_n)         loc_q[g] <= '0;
        else if (clr_stat1) loc_q[g] <= '0;
        else if (hit)       loc_q[g] <= wr_data;
      end
    end else begin : g_st0
      always_ff @(posedge clk) begin
        if (!rst_n)   loc_q[g] <= '0;
        else if (hit) loc_q[g] <= wr_data;
      end
    end
  end

  assign lock = loc_q[0][BYTE_W-1];

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_LOC; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = loc_q[i];
  end

  // R7
  stat1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat1 |=> loc_q[1] == '0);
  // R9
  snap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> fields == $past(snap_val));
endmodule

// File: rtl/cal_core.sv
module cal_core
  import cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [3:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic        cmd_load,
  input  logic        cmd_snap
);
  cal_time_t time_q, time_d, adv_t, sh_t;
  logic      lock, load_go;

  cal_advance u_adv (.cur(time_q), .nxt(adv_t));

  cal_shadow u_sh (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .snap_en(cmd_snap), .snap_val(time_d), .clr_stat1(load_go),
    .lock, .fields(sh_t)
  );

  assign load_go = cmd_load && !lock;

  always_comb begin
    if (load_go)       time_d = sh_t;
    else if (tick_1hz) time_d = adv_t;
    else               time_d = time_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= TIME_RST;
    else        time_q <= time_d;
  end

  // R7
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !lock) |=> time_q == $past(sh_t));
  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && lock && !tick_1hz) |=> $stable(time_q));
  // R9
  snap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_snap |=> sh_t == time_q);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !(cmd_load && !lock)) |=> $stable(time_q));
  // R3
  sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !cmd_load) |=> time_q.sec != $past(time_q.sec));
endmodule

// File: tb/sim_cal_core.sv
module sim_cal_core;
  logic       clk = 0, rst_n = 0, tick_1hz = 0, wr_en = 0, cmd_load = 0, cmd_snap = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cal_core u0 (.clk, .rst_n, .tick_1hz, .wr_en, .wr_addr, .wr_data,
               .rd_addr, .rd_data, .cmd_load, .cmd_snap);

  function automatic logic [63:0] tv(input logic [7:0] s, m, h, d, mo, y, wd, wk);
    return {wk, wd, y, mo, d, h, m, s};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pulse(input bit ld, input bit sn, input bit tk);
    @(negedge clk); cmd_load = ld; cmd_snap = sn; tick_1hz = tk;
    @(negedge clk); cmd_load = 0; cmd_snap = 0; tick_1hz = 0;
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic fill(input logic [63:0] v);
    for (int k = 0; k < 8; k++) host_wr(4'(k + 2), v[8*k +: 8]);
  endtask

  task automatic get_fields(output logic [63:0] v);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) begin rd(4'(k + 2), b); v[8*k +: 8] = b; end
  endtask

  task automatic set_clock(input logic [63:0] v);
    fill(v); pulse(1, 0, 0);
  endtask

  task automatic snap(output logic [63:0] v);
    pulse(0, 1, 0); get_fields(v);
  endtask

  task automatic t_reset;
    logic [7:0] b; logic [63:0] v;
    for (int a = 0; a < 10; a++) begin rd(4'(a), b); chk("R1 shadow", 64'(b), 64'h0); end
    snap(v);
    chk("R1 clock", v, tv(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00));
  endtask

  task automatic t_host;
    logic [7:0] b;
    host_wr(4'd3, 8'h47); rd(4'd3, b); chk("R2 rw", 64'(b), 64'h47);
    host_wr(4'd12, 8'hFF); rd(4'd12, b); chk("R2 unused", 64'(b), 64'h0);
  endtask

  task automatic roll(input string req, input logic [63:0] s, input logic [63:0] e);
    logic [63:0] v;
    set_clock(s); pulse(0, 0, 1); snap(v); chk(req, v, e);
  endtask

  task automatic t_load;
    logic [7:0] b; logic [63:0] v;
    host_wr(4'd1, 8'h3C);
    set_clock(tv(8'h12, 8'h34, 8'h05, 8'h17, 8'h08, 8'h42, 8'h03, 8'h33));
    rd(4'd1, b); chk("R7 stat1 cleared", 64'(b), 64'h0);
    fill(64'h0); snap(v);
    chk("R7 copy", v, tv(8'h12, 8'h34, 8'h05, 8'h17, 8'h08, 8'h42, 8'h03, 8'h33));
  endtask

  task automatic t_lock;
    logic [7:0] b; logic [63:0] v, a;
    a = tv(8'h20, 8'h20, 8'h20, 8'h20, 8'h10, 8'h20, 8'h02, 8'h40);
    set_clock(a);
    host_wr(4'd1, 8'h5A); host_wr(4'd0, 8'h80);
    fill(tv(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08));
    pulse(1, 0, 0);
    rd(4'd1, b); chk("R8 stat1 kept", 64'(b), 64'h5A);
    snap(v); chk("R8 clock kept", v, a);
    host_wr(4'd0, 8'h00);
  endtask

  task automatic t_snap_tick;
    logic [63:0] v;
    set_clock(tv(8'h59, 8'h59, 8'h10, 8'h05, 8'h03, 8'h11, 8'h02, 8'h09));
    pulse(0, 1, 1); get_fields(v);
    chk("R9 snap+tick", v, tv(8'h00, 8'h00, 8'h11, 8'h05, 8'h03, 8'h11, 8'h02, 8'h09));
    snap(v);
    chk("R9/R11 hold", v, tv(8'h00, 8'h00, 8'h11, 8'h05, 8'h03, 8'h11, 8'h02, 8'h09));
  endtask

  task automatic t_load_tick;
    logic [63:0] v, x;
    x = tv(8'h33, 8'h44, 8'h09, 8'h21, 8'h06, 8'h77, 8'h05, 8'h25);
    fill(x); pulse(1, 0, 1); fill(64'h0); snap(v);
    chk("R10 load beats tick", v, x);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_host();
    roll("R3 sec", tv(8'h58, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00),
                   tv(8'h59, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00));
    roll("R3 min carry", tv(8'h59, 8'h09, 8'h07, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00),
                         tv(8'h00, 8'h10, 8'h07, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00));
    roll("R4/R6 month end", tv(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h23, 8'h07, 8'h10),
                            tv(8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h23, 8'h01, 8'h11));
    roll("R4 feb common", tv(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h02, 8'h08),
                          tv(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, 8'h03, 8'h08));
    roll("R4 feb leap", tv(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h02, 8'h08),
                        tv(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h03, 8'h08));
    roll("R4 leap end", tv(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h03, 8'h08),
                        tv(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h24, 8'h04, 8'h08));
    roll("R4 30-day", tv(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h05, 8'h05, 8'h17),
                      tv(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h05, 8'h06, 8'h17));
    roll("R5/R6 year end", tv(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h03, 8'h52),
                           tv(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h04, 8'h00));
    roll("R6 week cap", tv(8'h59, 8'h59, 8'h23, 8'h29, 8'h12, 8'h05, 8'h07, 8'h52),
                        tv(8'h00, 8'h00, 8'h00, 8'h30, 8'h12, 8'h05, 8'h01, 8'h52));
    t_load();
    t_lock();
    t_snap_tick();
    t_load_tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule